// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block turns a base register value, an unsigned immediate and an add/subtract direction into the address of a single-word data access. It also produces the value that a writeback addressing mode leaves in the base register. A mode input chooses one of three forms. The plain offset form reads or writes at base ± offset and leaves the base alone. The pre-update form uses base ± offset both as the address and as the new base. The post-update form accesses the unmodified base and then moves the base to base ± offset.

The block works in three steps. The arithmetic and the mode selection take place when an instruction is accepted, and the result is registered into a memory request. The request is held on a valid/ready port until memory takes it. One cycle after that handshake, a registered writeback pulse and load-result pulse are presented. A word address with a nonzero low byte offset is rejected: only a one-cycle flag is raised.

Top module: `ls_agu`

## Requirements
- R1: Mode 0 (and the spare code 3) is plain offset: mem_addr equals in_base plus or minus in_offs, and wb_en stays low.
- R2: Mode 1 is pre-update: mem_addr and wb_value both equal in_base plus or minus in_offs, and wb_reg equals in_breg.
- R3: Mode 2 is post-update: mem_addr equals in_base unchanged, and wb_value equals in_base plus or minus in_offs.
- R4: in_sub = 1 subtracts the zero-extended offset, in_sub = 0 adds it, with 32-bit wrap-around.
- R5: An instruction accepted at clock edge N shows mem_req_valid after edge N. A handshake at edge M gives wb_en and ld_en after edge M, for one cycle, with ld_data equal to mem_rdata as it was at the handshake.
- R6: wb_en is raised only in modes 1 and 2, and never in two consecutive cycles.
- R7: A load in mode 1 or 2 whose in_dst equals in_breg raises ld_en with the loaded data and suppresses wb_en. A store in the same situation still writes the base back.
- R8: When the access address has bit 1 or bit 0 set, misalign pulses for one cycle after acceptance. No memory request follows and wb_en stays low.
- R9: While mem_req_valid is high and mem_req_ready is low, mem_addr, mem_we and mem_wdata hold their values and in_ready stays low.
- R10: A store (in_store = 1) drives mem_we = 1 and mem_wdata = in_wdata and never raises ld_en. A load drives mem_we = 0.
- R11: Starting at base A with offset 4, a pre-update load followed by a post-update load on the written-back base reads the word at A+4 twice and leaves the base at A+8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can accept an instruction |
| in_mode | input | 2 | 0 offset, 1 pre-update, 2 post-update, 3 as offset |
| in_sub | input | 1 | 1 subtracts the offset, 0 adds it |
| in_base | input | 32 | Base register value |
| in_offs | input | 12 | Unsigned immediate offset |
| in_store | input | 1 | 1 for store, 0 for load |
| in_wdata | input | 32 | Store data |
| in_dst | input | 5 | Load destination register index |
| in_breg | input | 5 | Base register index |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_addr | output | 32 | Access address |
| mem_we | output | 1 | Write enable |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the handshake cycle |
| wb_en | output | 1 | Base writeback strobe |
| wb_reg | output | 5 | Base register index to update |
| wb_value | output | 32 | New base value |
| ld_en | output | 1 | Load result strobe |
| ld_reg | output | 5 | Load destination index |
| ld_data | output | 32 | Loaded word |
| misalign | output | 1 | Unaligned word access rejected |

## Verification
The request fields appear one cycle after the accepting edge. The writeback and load strobes appear one cycle after the handshake edge and are gone one cycle later, and misalign appears one cycle after acceptance. Each scenario task drives its inputs on a falling edge and reads the request at the next falling edge. It then advances one falling edge at a time until it sees ready at the port, and reads the strobes at the falling edge after that and again one cycle later to confirm they lasted a single cycle. Stalled requests are checked at every waiting falling edge for held fields and a low in_ready.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;
  localparam int unsigned AGU_AW  = 32;
  localparam int unsigned AGU_OW  = 12;
  localparam int unsigned AGU_RW  = 5;
  localparam int unsigned AGU_LSB = 2;

  typedef enum logic [1:0] {
    AM_OFFSET = 2'd0,
    AM_PRE    = 2'd1,
    AM_POST   = 2'd2,
    AM_SPARE  = 2'd3
  } am_e;
endpackage

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import ls_agu_pkg::*;
#(
  parameter int unsigned AW  = AGU_AW,
  parameter int unsigned OW  = AGU_OW,
  parameter int unsigned LSB = AGU_LSB
) (
  input  logic [1:0]    mode,
  input  logic          sub,
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] offs,
  output logic [AW-1:0] acc_addr,
  output logic [AW-1:0] new_base,
  output logic          wb_mode,
  output logic          unaligned
);
  localparam int unsigned PADW = AW - OW;

  logic [AW-1:0] offs_ext;
  logic [AW-1:0] sum;

  assign offs_ext = {{PADW{1'b0}}, offs};
  assign sum      = sub ? (base - offs_ext) : (base + offs_ext);

  always_comb begin
    new_base = sum;
    wb_mode  = (mode == AM_PRE) || (mode == AM_POST);
    acc_addr = (mode == AM_POST) ? base : sum;
  end

  assign unaligned = |acc_addr[LSB-1:0];
endmodule

// File: rtl/agu_mem_stage.sv
module agu_mem_stage
  import ls_agu_pkg::*;
#(
  parameter int unsigned AW  = AGU_AW,
  parameter int unsigned RW  = AGU_RW,
  parameter int unsigned LSB = AGU_LSB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [AW-1:0] acc_addr,
  input  logic          store,
  input  logic [AW-1:0] wdata,
  input  logic          wb_mode,
  input  logic [AW-1:0] new_base,
  input  logic [RW-1:0] dst,
  input  logic [RW-1:0] breg,
  input  logic          mem_ready,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  output logic          req_we,
  output logic [AW-1:0] req_wdata,
  output logic          p_wb,
  output logic [AW-1:0] p_base,
  output logic [RW-1:0] p_dst,
  output logic [RW-1:0] p_breg,
  output logic          fire
);
  assign fire = req_valid && mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_we    <= 1'b0;
      req_wdata <= '0;
      p_wb      <= 1'b0;
      p_base    <= '0;
      p_dst     <= '0;
      p_breg    <= '0;
    end else if (accept) begin
      req_valid <= 1'b1;
      req_addr  <= acc_addr;
      req_we    <= store;
      req_wdata <= wdata;
      p_wb      <= wb_mode;
      p_base    <= new_base;
      p_dst     <= dst;
      p_breg    <= breg;
    end else if (fire) begin
      req_valid <= 1'b0;
    end
  end

  a_r9_req_held: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !mem_ready) |=> (req_valid && $stable(req_addr) && $stable(req_we)
                                   && $stable(req_wdata) && $stable(p_base) && $stable(p_wb)))
    else $error("a_r9_req_held");

  a_r8_req_aligned: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_addr[LSB-1:0] == '0))
    else $error("a_r8_req_aligned");
endmodule

// File: rtl/agu_wb_stage.sv
module agu_wb_stage
  import ls_agu_pkg::*;
#(
  parameter int unsigned AW = AGU_AW,
  parameter int unsigned RW = AGU_RW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic          store,
  input  logic          p_wb,
  input  logic [AW-1:0] p_base,
  input  logic [RW-1:0] p_dst,
  input  logic [RW-1:0] p_breg,
  input  logic [AW-1:0] rdata,
  output logic          wb_en,
  output logic [RW-1:0] wb_reg,
  output logic [AW-1:0] wb_value,
  output logic          ld_en,
  output logic [RW-1:0] ld_reg,
  output logic [AW-1:0] ld_data
);
  logic clash;
  assign clash = !store && (p_dst == p_breg);

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_en    <= 1'b0;
      wb_reg   <= '0;
      wb_value <= '0;
      ld_en    <= 1'b0;
      ld_reg   <= '0;
      ld_data  <= '0;
    end else begin
      wb_en <= fire && p_wb && !clash;
      ld_en <= fire && !store;
      if (fire) begin
        wb_reg   <= p_breg;
        wb_value <= p_base;
        ld_reg   <= p_dst;
        ld_data  <= rdata;
      end
    end
  end

  a_r6_wb_single: assert property (@(posedge clk) disable iff (rst)
    wb_en |=> !wb_en)
    else $error("a_r6_wb_single");

  a_r7_no_dual_write: assert property (@(posedge clk) disable iff (rst)
    (wb_en && ld_en) |-> (wb_reg != ld_reg))
    else $error("a_r7_no_dual_write");
endmodule

// File: rtl/ls_agu.sv
module ls_agu
  import ls_agu_pkg::*;
#(
  parameter int unsigned AW  = AGU_AW,
  parameter int unsigned OW  = AGU_OW,
  parameter int unsigned RW  = AGU_RW,
  parameter int unsigned LSB = AGU_LSB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_mode,
  input  logic          in_sub,
  input  logic [AW-1:0] in_base,
  input  logic [OW-1:0] in_offs,
  input  logic          in_store,
  input  logic [AW-1:0] in_wdata,
  input  logic [RW-1:0] in_dst,
  input  logic [RW-1:0] in_breg,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  output logic          wb_en,
  output logic [RW-1:0] wb_reg,
  output logic [AW-1:0] wb_value,
  output logic          ld_en,
  output logic [RW-1:0] ld_reg,
  output logic [AW-1:0] ld_data,
  output logic          misalign
);
  logic [AW-1:0] acc_addr, new_base, p_base;
  logic          wb_mode, unaligned, take, accept, fire, p_wb;
  logic [RW-1:0] p_dst, p_breg;

  agu_addr_calc #(.AW(AW), .OW(OW), .LSB(LSB)) u_calc (
    .mode(in_mode), .sub(in_sub), .base(in_base), .offs(in_offs),
    .acc_addr(acc_addr), .new_base(new_base), .wb_mode(wb_mode), .unaligned(unaligned)
  );

  assign in_ready = !mem_req_valid;
  assign take     = in_valid && in_ready;
  assign accept   = take && !unaligned;

  always_ff @(posedge clk) begin
    if (rst) misalign <= 1'b0;
    else     misalign <= take && unaligned;
  end

  agu_mem_stage #(.AW(AW), .RW(RW), .LSB(LSB)) u_mem (
    .clk(clk), .rst(rst), .accept(accept), .acc_addr(acc_addr), .store(in_store),
    .wdata(in_wdata), .wb_mode(wb_mode), .new_base(new_base), .dst(in_dst), .breg(in_breg),
    .mem_ready(mem_req_ready), .req_valid(mem_req_valid), .req_addr(mem_addr),
    .req_we(mem_we), .req_wdata(mem_wdata), .p_wb(p_wb), .p_base(p_base),
    .p_dst(p_dst), .p_breg(p_breg), .fire(fire)
  );

  agu_wb_stage #(.AW(AW), .RW(RW)) u_wb (
    .clk(clk), .rst(rst), .fire(fire), .store(mem_we), .p_wb(p_wb), .p_base(p_base),
    .p_dst(p_dst), .p_breg(p_breg), .rdata(mem_rdata), .wb_en(wb_en), .wb_reg(wb_reg),
    .wb_value(wb_value), .ld_en(ld_en), .ld_reg(ld_reg), .ld_data(ld_data)
  );

  a_r8_no_req_on_misalign: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (!mem_req_valid && !wb_en))
    else $error("a_r8_no_req_on_misalign");

  a_r5_strobe_after_handshake: assert property (@(posedge clk) disable iff (rst)
    (wb_en || ld_en) |-> $past(mem_req_valid && mem_req_ready))
    else $error("a_r5_strobe_after_handshake");

  a_r10_store_no_load: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready && mem_we) |=> !ld_en)
    else $error("a_r10_store_no_load");
endmodule

// File: tb/tb_ls_agu.sv
module tb_ls_agu;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        in_valid = 1'b0, in_ready, in_sub = 1'b0, in_store = 1'b0;
  logic [1:0]  in_mode = 2'd0;
  logic [31:0] in_base = '0, in_wdata = '0;
  logic [11:0] in_offs = '0;
  logic [4:0]  in_dst = '0, in_breg = '0;
  logic        mem_req_valid, mem_req_ready, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        wb_en, ld_en, misalign;
  logic [4:0]  wb_reg, ld_reg;
  logic [31:0] wb_value, ld_data;

  ls_agu dut (.*);

  int tests = 0, fails = 0, stall = 0, wait_cnt = 0;
  logic [31:0] mem [0:63];

  function automatic logic [31:0] pat(input int i);
    return 32'hA500_0000 | (i * 32'h0001_0203);
  endfunction

  assign mem_req_ready = mem_req_valid && (wait_cnt >= stall);
  assign mem_rdata     = mem[mem_addr[7:2]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] <= pat(i);
      wait_cnt <= 0;
    end else begin
      if (mem_req_valid && mem_req_ready && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
      wait_cnt <= (mem_req_valid && !mem_req_ready) ? wait_cnt + 1 : 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic        r_req, r_we, r_mis, r_held, r_busy, r_wb, r_ld, r_wb2, r_ld2;
  logic [31:0] r_addr, r_wdata, r_wbv, r_ldd;
  logic [4:0]  r_wbr, r_ldr;

  task automatic run_op(input logic [1:0] m, input logic s, input logic [31:0] b,
                        input logic [11:0] o, input logic st, input logic [31:0] wd,
                        input logic [4:0] d, input logic [4:0] br, input int stl);
    stall = stl;
    @(negedge clk);
    in_mode = m; in_sub = s; in_base = b; in_offs = o; in_store = st;
    in_wdata = wd; in_dst = d; in_breg = br; in_valid = 1'b1;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    r_req = mem_req_valid; r_addr = mem_addr; r_we = mem_we; r_wdata = mem_wdata;
    r_mis = misalign; r_held = 1'b1; r_busy = 1'b1;
    if (r_req) begin
      while (!mem_req_ready) begin
        if (in_ready || mem_addr !== r_addr || mem_we !== r_we || mem_wdata !== r_wdata)
          r_held = 1'b0;
        if (in_ready) r_busy = 1'b0;
        @(negedge clk);
      end
    end
    @(negedge clk);
    r_wb = wb_en; r_wbv = wb_value; r_wbr = wb_reg;
    r_ld = ld_en; r_ldd = ld_data; r_ldr = ld_reg;
    @(negedge clk);
    r_wb2 = wb_en; r_ld2 = ld_en;
  endtask

  task automatic t_reset;
    chk("R5 reset in_ready", {31'b0, in_ready}, 32'd1);
    chk("R5 reset req_valid", {31'b0, mem_req_valid}, 32'd0);
    chk("R6 reset wb_en", {31'b0, wb_en}, 32'd0);
    chk("R8 reset misalign", {31'b0, misalign}, 32'd0);
  endtask

  task automatic t_offset;
    run_op(2'd0, 1'b0, 32'h40, 12'h8, 1'b0, 0, 5'd1, 5'd2, 0);
    chk("R1 offset addr", r_addr, 32'h48);
    chk("R1 offset no wb", {31'b0, r_wb}, 32'd0);
    chk("R5 offset ld_data", r_ldd, pat(18));
    chk("R5 offset ld_en", {31'b0, r_ld}, 32'd1);
    chk("R5 ld single cycle", {31'b0, r_ld2}, 32'd0);
    chk("R10 load we low", {31'b0, r_we}, 32'd0);
    run_op(2'd3, 1'b1, 32'h30, 12'h10, 1'b0, 0, 5'd1, 5'd2, 0);
    chk("R1 spare mode addr", r_addr, 32'h20);
    chk("R1 spare mode no wb", {31'b0, r_wb}, 32'd0);
  endtask

  task automatic t_pre;
    run_op(2'd1, 1'b0, 32'h20, 12'h4, 1'b0, 0, 5'd1, 5'd2, 0);
    chk("R2 pre addr", r_addr, 32'h24);
    chk("R2 pre wb_value", r_wbv, 32'h24);
    chk("R2 pre wb_reg", {27'b0, r_wbr}, 32'd2);
    chk("R6 pre wb_en", {31'b0, r_wb}, 32'd1);
    chk("R6 wb single cycle", {31'b0, r_wb2}, 32'd0);
    chk("R2 pre ld_data", r_ldd, pat(9));
  endtask

  task automatic t_post;
    run_op(2'd2, 1'b0, 32'h20, 12'h4, 1'b0, 0, 5'd4, 5'd5, 0);
    chk("R3 post addr", r_addr, 32'h20);
    chk("R3 post wb_value", r_wbv, 32'h24);
    chk("R3 post ld_data", r_ldd, pat(8));
    chk("R3 post ld_reg", {27'b0, r_ldr}, 32'd4);
  endtask

  task automatic t_sub_wrap;
    run_op(2'd1, 1'b1, 32'h4, 12'h8, 1'b0, 0, 5'd1, 5'd2, 0);
    chk("R4 wrap addr", r_addr, 32'hFFFF_FFFC);
    chk("R4 wrap wb_value", r_wbv, 32'hFFFF_FFFC);
    run_op(2'd2, 1'b0, 32'hFFFF_FFFC, 12'h8, 1'b0, 0, 5'd1, 5'd2, 0);
    chk("R4 add wrap wb_value", r_wbv, 32'h4);
  endtask

  task automatic t_sequence;
    logic [31:0] a1;
    run_op(2'd1, 1'b0, 32'h80, 12'h4, 1'b0, 0, 5'd0, 5'd1, 0);
    chk("R11 first read", r_ldd, pat(33));
    a1 = r_wbv;
    run_op(2'd2, 1'b0, a1, 12'h4, 1'b0, 0, 5'd3, 5'd1, 0);
    chk("R11 second read", r_ldd, pat(33));
    chk("R11 final base", r_wbv, 32'h88);
  endtask

  task automatic t_clash;
    run_op(2'd1, 1'b0, 32'h10, 12'h4, 1'b0, 0, 5'd3, 5'd3, 0);
    chk("R7 clash wb suppressed", {31'b0, r_wb}, 32'd0);
    chk("R7 clash ld_en", {31'b0, r_ld}, 32'd1);
    chk("R7 clash ld_data", r_ldd, pat(5));
    run_op(2'd2, 1'b0, 32'hF0, 12'h4, 1'b1, 32'h1234_5678, 5'd3, 5'd3, 0);
    chk("R7 store same index keeps wb", {31'b0, r_wb}, 32'd1);
    chk("R10 store no ld_en", {31'b0, r_ld}, 32'd0);
  endtask

  task automatic t_misalign;
    run_op(2'd1, 1'b0, 32'h40, 12'h2, 1'b0, 0, 5'd1, 5'd2, 0);
    chk("R8 misalign flag", {31'b0, r_mis}, 32'd1);
    chk("R8 no request", {31'b0, r_req}, 32'd0);
    chk("R8 no wb", {31'b0, r_wb}, 32'd0);
    run_op(2'd2, 1'b0, 32'h41, 12'h3, 1'b0, 0, 5'd1, 5'd2, 0);
    chk("R8 post misalign flag", {31'b0, r_mis}, 32'd1);
    chk("R8 post no wb", {31'b0, r_wb}, 32'd0);
  endtask

  task automatic t_stall;
    run_op(2'd1, 1'b0, 32'hC0, 12'h10, 1'b1, 32'hDEAD_BEEF, 5'd6, 5'd7, 3);
    chk("R9 fields held", {31'b0, r_held}, 32'd1);
    chk("R9 in_ready low", {31'b0, r_busy}, 32'd1);
    chk("R10 store we", {31'b0, r_we}, 32'd1);
    chk("R10 store wdata", r_wdata, 32'hDEAD_BEEF);
    chk("R2 stalled pre wb", r_wbv, 32'hD0);
    run_op(2'd0, 1'b0, 32'hD0, 12'h0, 1'b0, 0, 5'd1, 5'd2, 2);
    chk("R10 stored word read back", r_ldd, 32'hDEAD_BEEF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_offset;
    t_pre;
    t_post;
    t_sub_wrap;
    t_sequence;
    t_clash;
    t_misalign;
    t_stall;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule